// File: doc/BRIEF.md
# Receive Packet Handler with CRC Flush

This block sits behind a demodulator that has already locked onto the preamble and sync word. It receives a byte stream, one byte per cycle when `inValid` is high, and a single-cycle `sopPulse` that marks where a packet starts. It frames the packet in one of two ways. In variable-length mode the first byte gives the length. In fixed-length mode the byte count comes from configuration. It can drop packets whose first payload byte does not match a device address. It can check a two-byte CRC and append two status bytes. Accepted bytes go into a 64-byte receive FIFO.

Software reads the FIFO through a show-ahead read port. A packet's bytes stay invisible to the reader until the packet has been fully judged. If automatic flushing is on and the CRC check fails, the whole FIFO is emptied. This includes earlier packets that have not been read yet, so the reader must drain each packet before the next one arrives.

After each packet, whether it completes or is dropped, a configuration bit chooses the next state. The block either keeps listening for another start pulse or goes idle until `rxStart` is pulsed.

Top module: `rxPktHandler`

## Requirements
- R1: After reset the FIFO reports zero bytes (`fifoCount` = 0), `rxActive` is 0, and neither `pktDone` nor `pktDropped` is asserted.
- R2: In variable-length mode (`cfgVarLen` = 1) the first byte after the start pulse is a length L. L counts the address byte, if used, and the payload. The FIFO receives L itself followed by exactly L further bytes. L = 0 is a valid empty packet.
- R3: In fixed-length mode (`cfgVarLen` = 0) exactly `cfgFixLen` bytes are taken after the start pulse and written to the FIFO.
- R4: With `cfgAddrEn` = 1, the first byte after the length byte (variable mode) or the first byte (fixed mode) is compared with `cfgDevAddr`. On a mismatch, `pktDropped` pulses for one cycle, every byte already written for that packet is discarded, the remaining bytes are ignored, and `fifoCount` does not change.
- R5: With `cfgCrcEn` = 1, the two bytes after the payload are a checksum, high byte first. The checksum is CRC-16 with polynomial 0x8005, initial value 0xFFFF, MSB-first and no final inversion, computed over the length, address and payload bytes. It is not stored. `pktCrcOk` is valid while `pktDone` is high. With `cfgCrcEn` = 0 no checksum bytes are expected and `pktCrcOk` is 0.
- R6: With `cfgAutoFlush` = 1 and `cfgCrcEn` = 1, a CRC mismatch empties the entire FIFO, including earlier unread packets, so `fifoCount` is 0 in the cycle after `pktDone`.
- R7: With `cfgAppend` = 1, two bytes follow the payload in the FIFO: first `rssiIn`, then a byte with the CRC result in bit 7 and `lqiIn` in bits 6:0.
- R8: With `cfgAutoFlush` = 1, the limit on L is 63 in variable mode and the limit on `cfgFixLen` is 64 in fixed mode. Both limits drop by 2 when `cfgAppend` = 1. A packet over its limit is dropped as in R4.
- R9: From idle, `rxStart` enters listening (`rxActive` = 1), and start pulses are ignored while idle. After `pktDone` or `pktDropped`, the block keeps listening if `cfgStayRx` = 1 and goes idle otherwise.
- R10: `fifoCount` counts only bytes of completed packets. It does not grow while a packet is being received, and it changes from the commit in the cycle after `pktDone`.
- R11: `rdData` shows the oldest readable byte. `rdEn` with `fifoCount` > 0 removes that byte, and bytes come out in the order they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxStart | input | 1 | Pulse: leave idle and listen for packets |
| sopPulse | input | 1 | Start-of-packet pulse from sync detection |
| inValid | input | 1 | `inByte` holds a received byte |
| inByte | input | 8 | Received byte |
| cfgVarLen | input | 1 | 1 = first byte is length, 0 = fixed length |
| cfgFixLen | input | 7 | Byte count in fixed-length mode |
| cfgAddrEn | input | 1 | Enable address filtering |
| cfgDevAddr | input | 8 | Address to match |
| cfgCrcEn | input | 1 | Expect and check a two-byte CRC |
| cfgAutoFlush | input | 1 | Flush FIFO on CRC failure and enforce length limits |
| cfgAppend | input | 1 | Append two status bytes |
| cfgStayRx | input | 1 | After a packet: 1 = keep listening, 0 = idle |
| rssiIn | input | 8 | Signal strength for status byte 1 |
| lqiIn | input | 7 | Link quality for status byte 2 |
| rdEn | input | 1 | Pop the byte on `rdData` |
| rdData | output | 8 | Oldest readable FIFO byte |
| fifoCount | output | 7 | Number of readable bytes |
| pktDone | output | 1 | One-cycle pulse: packet fully received |
| pktDropped | output | 1 | One-cycle pulse: packet discarded (address or length) |
| pktCrcOk | output | 1 | CRC result, valid with `pktDone` |
| rxActive | output | 1 | Block is not idle |

## Verification
The bench targets the rollback after an address mismatch. A design that kept the already-written length and address bytes would put stale bytes ahead of the next good packet, and the scoreboard would see them out of order. It fails a CRC while an earlier good packet is still unread; flushing only the bad packet would leave that packet readable. Each length limit is tried at the edge value and one past it, with and without status bytes, to catch an off-by-two. It also probes `fifoCount` halfway through a packet, where a design that exposed uncommitted bytes would already report a larger count.

// File: rtl/rxPktPkg.sv
package rxPktPkg;

  typedef enum logic [1:0] {
    SEL_IN   = 2'd0,
    SEL_RSSI = 2'd1,
    SEL_STAT = 2'd2
  } wrSelT;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_LISTEN = 4'd1,
    ST_LEN    = 4'd2,
    ST_PAY    = 4'd3,
    ST_CHI    = 4'd4,
    ST_CLO    = 4'd5,
    ST_ST1    = 4'd6,
    ST_ST2    = 4'd7,
    ST_DONE   = 4'd8,
    ST_DROP   = 4'd9
  } stateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic  wrEn;
    wrSelT wrSel;
    logic  crcInit;
    logic  crcUpd;
    logic  crcLatchHi;
    logic  crcCheck;
    logic  loadLen;
    logic  loadFix;
    logic  decRemain;
    logic  commit;
    logic  rollback;
    logic  flushAll;
  } strobeT;

  // One byte of CRC-16, polynomial 0x8005, MSB first
  function automatic logic [15:0] crcStep(input logic [15:0] cur, input logic [7:0] dat);
    logic [15:0] c;
    logic fb;
    c = cur;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ dat[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxPktDatapath.sv
module rxPktDatapath
  import rxPktPkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int MAXVAR = 63,
  parameter int MAXFIX = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strobe,
  input  logic [7:0]    inByte,
  input  logic [6:0]    cfgFixLen,
  input  logic          cfgAddrEn,
  input  logic [7:0]    cfgDevAddr,
  input  logic          cfgAutoFlush,
  input  logic          cfgAppend,
  input  logic [7:0]    rssiIn,
  input  logic [6:0]    lqiIn,
  input  logic          rdEn,
  output logic [7:0]    rdData,
  output logic [CW-1:0] fifoCount,
  output logic          remainLast,
  output logic          lenZero,
  output logic          fixZero,
  output logic          lenTooBig,
  output logic          fixTooBig,
  output logic          addrMiss,
  output logic          crcOk
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr, cmtPtr;
  logic          full;
  logic          doWrite;
  logic [7:0]    wrByte;
  logic [7:0]    remain;
  logic [15:0]   crcReg;
  logic [7:0]    crcHi;
  logic [7:0]    limitVar, limitFix;

  assign full    = (wrPtr - rdPtr) == PW'(DEPTH);
  assign doWrite = strobe.wrEn && !full;

  always_comb begin
    case (strobe.wrSel)
      SEL_RSSI: wrByte = rssiIn;
      SEL_STAT: wrByte = {crcOk, lqiIn};
      default:  wrByte = inByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr[AW-1:0]] <= wrByte;
  end

  // Pointer management: write, commit, rollback, flush
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      cmtPtr <= '0;
    end else begin
      if (strobe.rollback)  wrPtr <= cmtPtr;
      else if (doWrite)     wrPtr <= wrPtr + PW'(1);
      if (strobe.flushAll) begin
        rdPtr  <= wrPtr;
        cmtPtr <= wrPtr;
      end else begin
        if (rdEn && (cmtPtr != rdPtr)) rdPtr <= rdPtr + PW'(1);
        if (strobe.commit) cmtPtr <= wrPtr;
      end
    end
  end

  assign rdData    = mem[rdPtr[AW-1:0]];
  assign fifoCount = CW'(cmtPtr - rdPtr);

  // Byte counter
  always_ff @(posedge clk) begin
    if (!rstN)                 remain <= '0;
    else if (strobe.loadLen)   remain <= inByte;
    else if (strobe.loadFix)   remain <= {1'b0, cfgFixLen};
    else if (strobe.decRemain) remain <= remain - 8'd1;
  end

  assign limitVar   = 8'(MAXVAR) - (cfgAppend ? 8'd2 : 8'd0);
  assign limitFix   = 8'(MAXFIX) - (cfgAppend ? 8'd2 : 8'd0);
  assign remainLast = remain == 8'd1;
  assign lenZero    = inByte == 8'd0;
  assign fixZero    = cfgFixLen == 7'd0;
  assign lenTooBig  = cfgAutoFlush && (inByte > limitVar);
  assign fixTooBig  = cfgAutoFlush && ({1'b0, cfgFixLen} > limitFix);
  assign addrMiss   = cfgAddrEn && (inByte != cfgDevAddr);

  // CRC engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= 16'hFFFF;
      crcHi  <= '0;
      crcOk  <= 1'b0;
    end else begin
      if (strobe.crcInit) begin
        crcReg <= 16'hFFFF;
        crcOk  <= 1'b0;
      end else begin
        if (strobe.crcUpd)     crcReg <= crcStep(crcReg, inByte);
        if (strobe.crcLatchHi) crcHi  <= inByte;
        if (strobe.crcCheck)   crcOk  <= crcReg == {crcHi, inByte};
      end
    end
  end

endmodule

// File: rtl/rxPktControl.sv
module rxPktControl
  import rxPktPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxStart,
  input  logic   sopPulse,
  input  logic   inValid,
  input  logic   cfgVarLen,
  input  logic   cfgCrcEn,
  input  logic   cfgAppend,
  input  logic   cfgAutoFlush,
  input  logic   cfgStayRx,
  input  logic   remainLast,
  input  logic   lenZero,
  input  logic   fixZero,
  input  logic   lenTooBig,
  input  logic   fixTooBig,
  input  logic   addrMiss,
  input  logic   crcOk,
  output strobeT strobe,
  output logic   pktDone,
  output logic   pktDropped,
  output logic   rxActive
);

  stateT state, nextState;
  stateT afterPay, leaveTo;
  logic  firstPay;

  assign afterPay = cfgCrcEn ? ST_CHI : (cfgAppend ? ST_ST1 : ST_DONE);
  assign leaveTo  = cfgStayRx ? ST_LISTEN : ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  firstPay <= 1'b1;
    else if (state != ST_PAY)   firstPay <= 1'b1;
    else if (inValid)           firstPay <= 1'b0;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (rxStart) nextState = ST_LISTEN;
      ST_LISTEN: begin
        if (sopPulse) begin
          strobe.crcInit = 1'b1;
          if (cfgVarLen) nextState = ST_LEN;
          else if (fixTooBig) nextState = ST_DROP;
          else begin
            strobe.loadFix = 1'b1;
            nextState = fixZero ? afterPay : ST_PAY;
          end
        end
      end
      ST_LEN: begin
        if (inValid) begin
          strobe.wrEn    = 1'b1;
          strobe.crcUpd  = 1'b1;
          strobe.loadLen = 1'b1;
          if (lenTooBig)    nextState = ST_DROP;
          else if (lenZero) nextState = afterPay;
          else              nextState = ST_PAY;
        end
      end
      ST_PAY: begin
        if (inValid) begin
          strobe.wrEn      = 1'b1;
          strobe.crcUpd    = 1'b1;
          strobe.decRemain = 1'b1;
          if (firstPay && addrMiss) nextState = ST_DROP;
          else if (remainLast)      nextState = afterPay;
        end
      end
      ST_CHI: begin
        if (inValid) begin
          strobe.crcLatchHi = 1'b1;
          nextState = ST_CLO;
        end
      end
      ST_CLO: begin
        if (inValid) begin
          strobe.crcCheck = 1'b1;
          nextState = cfgAppend ? ST_ST1 : ST_DONE;
        end
      end
      ST_ST1: begin
        strobe.wrEn  = 1'b1;
        strobe.wrSel = SEL_RSSI;
        nextState    = ST_ST2;
      end
      ST_ST2: begin
        strobe.wrEn  = 1'b1;
        strobe.wrSel = SEL_STAT;
        nextState    = ST_DONE;
      end
      ST_DONE: begin
        if (cfgAutoFlush && cfgCrcEn && !crcOk) strobe.flushAll = 1'b1;
        else                                    strobe.commit   = 1'b1;
        nextState = leaveTo;
      end
      ST_DROP: begin
        strobe.rollback = 1'b1;
        nextState = leaveTo;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign pktDone    = state == ST_DONE;
  assign pktDropped = state == ST_DROP;
  assign rxActive   = state != ST_IDLE;

endmodule

// File: rtl/rxPktHandler.sv
module rxPktHandler
  import rxPktPkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int MAXVAR = 63,
  parameter int MAXFIX = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxStart,
  input  logic          sopPulse,
  input  logic          inValid,
  input  logic [7:0]    inByte,
  input  logic          cfgVarLen,
  input  logic [6:0]    cfgFixLen,
  input  logic          cfgAddrEn,
  input  logic [7:0]    cfgDevAddr,
  input  logic          cfgCrcEn,
  input  logic          cfgAutoFlush,
  input  logic          cfgAppend,
  input  logic          cfgStayRx,
  input  logic [7:0]    rssiIn,
  input  logic [6:0]    lqiIn,
  input  logic          rdEn,
  output logic [7:0]    rdData,
  output logic [CW-1:0] fifoCount,
  output logic          pktDone,
  output logic          pktDropped,
  output logic          pktCrcOk,
  output logic          rxActive
);

  strobeT strobe;
  logic remainLast, lenZero, fixZero, lenTooBig, fixTooBig, addrMiss, crcOk;

  rxPktControl u_ctrl (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .sopPulse(sopPulse), .inValid(inValid),
    .cfgVarLen(cfgVarLen), .cfgCrcEn(cfgCrcEn), .cfgAppend(cfgAppend),
    .cfgAutoFlush(cfgAutoFlush), .cfgStayRx(cfgStayRx),
    .remainLast(remainLast), .lenZero(lenZero), .fixZero(fixZero),
    .lenTooBig(lenTooBig), .fixTooBig(fixTooBig), .addrMiss(addrMiss), .crcOk(crcOk),
    .strobe(strobe), .pktDone(pktDone), .pktDropped(pktDropped), .rxActive(rxActive)
  );

  rxPktDatapath #(.DEPTH(DEPTH), .MAXVAR(MAXVAR), .MAXFIX(MAXFIX)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inByte(inByte), .cfgFixLen(cfgFixLen),
    .cfgAddrEn(cfgAddrEn), .cfgDevAddr(cfgDevAddr), .cfgAutoFlush(cfgAutoFlush),
    .cfgAppend(cfgAppend), .rssiIn(rssiIn), .lqiIn(lqiIn), .rdEn(rdEn),
    .rdData(rdData), .fifoCount(fifoCount), .remainLast(remainLast), .lenZero(lenZero),
    .fixZero(fixZero), .lenTooBig(lenTooBig), .fixTooBig(fixTooBig),
    .addrMiss(addrMiss), .crcOk(crcOk)
  );

  assign pktCrcOk = crcOk;

endmodule

// File: rtl/rxPktChecker.sv
module rxPktChecker #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdEn,
  input logic          cfgStayRx,
  input logic          cfgCrcEn,
  input logic          cfgAutoFlush,
  input logic          pktDone,
  input logic          pktDropped,
  input logic          pktCrcOk,
  input logic          rxActive,
  input logic [CW-1:0] fifoCount
);

  // R6
  crc_flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktDone && cfgCrcEn && cfgAutoFlush && !pktCrcOk) |=> (fifoCount == '0));

  // R4
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktDropped && !rdEn) |=> $stable(fifoCount));

  // R10
  hidden_until_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pktDone && !rdEn) |=> $stable(fifoCount));

  // R9
  idle_after_packet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pktDone || pktDropped) && !cfgStayRx) |=> !rxActive);

  // R11
  read_pops_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (fifoCount != '0) && !pktDone) |=> (fifoCount == $past(fifoCount) - CW'(1)));

endmodule

bind rxPktHandler rxPktChecker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .cfgStayRx(cfgStayRx), .cfgCrcEn(cfgCrcEn),
  .cfgAutoFlush(cfgAutoFlush), .pktDone(pktDone), .pktDropped(pktDropped),
  .pktCrcOk(pktCrcOk), .rxActive(rxActive), .fifoCount(fifoCount)
);

// File: tb/tb_rxPktHandler.sv
`timescale 1ns/1ps
module tb_rxPktHandler;

  logic       clk = 1'b0;
  logic       rstN, rxStart, sopPulse, inValid;
  logic [7:0] inByte;
  logic       cfgVarLen, cfgAddrEn, cfgCrcEn, cfgAutoFlush, cfgAppend, cfgStayRx;
  logic [6:0] cfgFixLen;
  logic [7:0] cfgDevAddr, rssiIn;
  logic [6:0] lqiIn;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic [6:0] fifoCount;
  logic       pktDone, pktDropped, pktCrcOk, rxActive;

  always #4 clk = ~clk;

  rxPktHandler dut (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .sopPulse(sopPulse), .inValid(inValid),
    .inByte(inByte), .cfgVarLen(cfgVarLen), .cfgFixLen(cfgFixLen), .cfgAddrEn(cfgAddrEn),
    .cfgDevAddr(cfgDevAddr), .cfgCrcEn(cfgCrcEn), .cfgAutoFlush(cfgAutoFlush),
    .cfgAppend(cfgAppend), .cfgStayRx(cfgStayRx), .rssiIn(rssiIn), .lqiIn(lqiIn),
    .rdEn(rdEn), .rdData(rdData), .fifoCount(fifoCount), .pktDone(pktDone),
    .pktDropped(pktDropped), .pktCrcOk(pktCrcOk), .rxActive(rxActive)
  );

  int nChecks = 0, nFails = 0;
  int doneCnt = 0, dropCnt = 0;
  bit lastCrc = 1'b0;
  bit drainOn = 1'b0;
  bit gapMode = 1'b0;
  logic [7:0] expQ[$];
  logic [7:0] bodyQ[$];
  logic [7:0] monExp;
  bit sDone, sDrop;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [7:0] q[$]);
    logic [15:0] c;
    c = 16'hFFFF;
    foreach (q[i]) begin
      c = c ^ {q[i], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  // Outcome counters
  always @(negedge clk) begin
    if (pktDone) begin
      doneCnt++;
      lastCrc = pktCrcOk;
    end
    if (pktDropped) dropCnt++;
  end

  // Scoreboard monitor: pops expected bytes as readable data appears
  always @(negedge clk) begin
    if (drainOn && fifoCount != 7'd0) begin
      if (expQ.size() == 0) chk(1'b0, "R11 unexpected byte", rdData, -1);
      else begin
        monExp = expQ.pop_front();
        chk(rdData == monExp, "R11 data order", rdData, monExp);
      end
      rdEn = 1'b1;
    end else begin
      rdEn = 1'b0;
    end
  end

  task automatic mkBody(input int n, input int seed);
    bodyQ.delete();
    for (int i = 0; i < n; i++) bodyQ.push_back(8'((seed * 7 + i * 13 + 1) & 8'hFF));
  endtask

  // Driver: builds the stream from bodyQ, predicts the FIFO content, drives it
  task automatic sendPacket(input bit corrupt, input bit expCommit, input bit probe,
                            input string req, output bit sawDone, output bit sawDrop);
    logic [7:0] st[$];
    logic [15:0] c;
    int preDone, preDrop, preCount;
    bit expOk;
    st = {};
    if (cfgVarLen) st.push_back(8'(bodyQ.size()));
    foreach (bodyQ[i]) st.push_back(bodyQ[i]);
    c = refCrc(st);
    expOk = cfgCrcEn && !corrupt;
    if (expCommit) begin
      foreach (st[i]) expQ.push_back(st[i]);
      if (cfgAppend) begin
        expQ.push_back(rssiIn);
        expQ.push_back({expOk, lqiIn});
      end
    end
    if (cfgCrcEn) begin
      st.push_back(c[15:8]);
      st.push_back(corrupt ? (c[7:0] ^ 8'h01) : c[7:0]);
    end
    preDone = doneCnt;
    preDrop = dropCnt;
    preCount = fifoCount;
    sopPulse = 1'b1;
    @(negedge clk);
    sopPulse = 1'b0;
    foreach (st[i]) begin
      inValid = 1'b1;
      inByte  = st[i];
      // R10: no growth of the readable count mid-packet
      if (probe && i == st.size() / 2) chk(fifoCount == 7'(preCount), "R10 count mid-packet", fifoCount, preCount);
      @(negedge clk);
      if (gapMode) begin
        inValid = 1'b0;
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    for (int k = 0; k < 40; k++) begin
      #1;
      if (doneCnt != preDone || dropCnt != preDrop) break;
      @(negedge clk);
    end
    sawDone = doneCnt != preDone;
    sawDrop = dropCnt != preDrop;
    if (sawDone) chk(lastCrc == expOk, {req, " crc result"}, lastCrc, expOk);
    @(negedge clk);
  endtask

  task automatic waitDrain(input string req);
    for (int i = 0; i < 400; i++) begin
      if (expQ.size() == 0 && fifoCount == 7'd0) break;
      @(negedge clk);
    end
    chk(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    rstN = 1'b0; rxStart = 1'b0; sopPulse = 1'b0; inValid = 1'b0; inByte = '0;
    cfgVarLen = 1'b1; cfgFixLen = 7'd0; cfgAddrEn = 1'b0; cfgDevAddr = 8'h5A;
    cfgCrcEn = 1'b1; cfgAutoFlush = 1'b0; cfgAppend = 1'b1; cfgStayRx = 1'b1;
    rssiIn = 8'hC3; lqiIn = 7'h2B;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(fifoCount == 7'd0, "R1 count after reset", fifoCount, 0);
    chk(rxActive == 1'b0, "R1 idle after reset", rxActive, 0);
    chk(!pktDone && !pktDropped, "R1 no pulses", pktDone + pktDropped, 0);

    // R9 start pulse while idle is ignored
    mkBody(3, 1);
    sendPacket(1'b0, 1'b0, 1'b0, "R9 idle", sDone, sDrop);
    chk(!sDone && !sDrop && fifoCount == 7'd0, "R9 sop ignored in idle", sDone + sDrop, 0);

    rxStart = 1'b1;
    @(negedge clk);
    rxStart = 1'b0;
    chk(rxActive == 1'b1, "R9 listening after rxStart", rxActive, 1);

    // R2 R5 R7 variable length, good CRC, status appended
    drainOn = 1'b1;
    mkBody(5, 2);
    sendPacket(1'b0, 1'b1, 1'b0, "R5 var good", sDone, sDrop);
    chk(sDone, "R2 var packet completes", sDone, 1);
    waitDrain("R2 var bytes delivered");

    // R2 zero length, with gaps between bytes
    gapMode = 1'b1;
    mkBody(0, 3);
    sendPacket(1'b0, 1'b1, 1'b0, "R5 zero len", sDone, sDrop);
    chk(sDone, "R2 zero-length completes", sDone, 1);
    waitDrain("R2 zero-length delivered");
    gapMode = 1'b0;

    // R3 fixed length, no status
    cfgVarLen = 1'b0; cfgAppend = 1'b0; cfgFixLen = 7'd6;
    mkBody(6, 4);
    sendPacket(1'b0, 1'b1, 1'b0, "R5 fixed", sDone, sDrop);
    chk(sDone, "R3 fixed packet completes", sDone, 1);
    waitDrain("R3 fixed bytes delivered");

    // R4 address match then mismatch, then good packet checks rollback
    cfgVarLen = 1'b1; cfgAppend = 1'b1; cfgAddrEn = 1'b1;
    mkBody(4, 5); bodyQ[0] = 8'h5A;
    sendPacket(1'b0, 1'b1, 1'b0, "R4 match", sDone, sDrop);
    chk(sDone && !sDrop, "R4 matching address accepted", sDone, 1);
    waitDrain("R4 match delivered");
    drainOn = 1'b0;
    mkBody(6, 6); bodyQ[0] = 8'h33;
    sendPacket(1'b0, 1'b0, 1'b0, "R4 miss", sDone, sDrop);
    chk(sDrop && !sDone, "R4 mismatch dropped", sDrop, 1);
    chk(fifoCount == 7'd0, "R4 count unchanged", fifoCount, 0);
    drainOn = 1'b1;
    mkBody(3, 7); bodyQ[0] = 8'h5A;
    sendPacket(1'b0, 1'b1, 1'b0, "R4 after miss", sDone, sDrop);
    waitDrain("R4 no stale bytes after drop");
    cfgAddrEn = 1'b0;

    // R5 R7 bad CRC without flush: kept, status bit 7 clear
    mkBody(4, 8);
    sendPacket(1'b1, 1'b1, 1'b0, "R5 bad crc", sDone, sDrop);
    chk(sDone, "R5 bad crc packet completes", sDone, 1);
    waitDrain("R7 status with crc fail");

    // R5 R7 CRC disabled: no checksum bytes, result 0
    cfgCrcEn = 1'b0;
    mkBody(4, 9);
    sendPacket(1'b0, 1'b1, 1'b0, "R5 crc off", sDone, sDrop);
    chk(sDone, "R5 crc-off packet completes", sDone, 1);
    waitDrain("R7 status with crc off");
    cfgCrcEn = 1'b1;

    // R10 readable count stays put mid-packet, R6 flush wipes earlier packet
    drainOn = 1'b0; cfgAutoFlush = 1'b1;
    mkBody(8, 10);
    sendPacket(1'b0, 1'b0, 1'b1, "R10 good", sDone, sDrop);
    chk(fifoCount == 7'd11, "R10 count after commit", fifoCount, 11);
    mkBody(5, 11);
    sendPacket(1'b1, 1'b0, 1'b0, "R6 bad", sDone, sDrop);
    chk(sDone, "R6 bad packet completes", sDone, 1);
    chk(fifoCount == 7'd0, "R6 whole FIFO flushed", fifoCount, 0);
    drainOn = 1'b1;

    // R8 length limits
    cfgAppend = 1'b0;
    mkBody(63, 12);
    sendPacket(1'b0, 1'b1, 1'b0, "R8 var 63", sDone, sDrop);
    chk(sDone && !sDrop, "R8 var 63 accepted", sDone, 1);
    waitDrain("R8 var 63 delivered");
    mkBody(64, 13);
    sendPacket(1'b0, 1'b0, 1'b0, "R8 var 64", sDone, sDrop);
    chk(sDrop && !sDone, "R8 var 64 dropped", sDrop, 1);
    cfgAppend = 1'b1;
    mkBody(62, 14);
    sendPacket(1'b0, 1'b0, 1'b0, "R8 var 62 app", sDone, sDrop);
    chk(sDrop && !sDone, "R8 var 62 dropped with status", sDrop, 1);
    mkBody(61, 15);
    sendPacket(1'b0, 1'b1, 1'b0, "R8 var 61 app", sDone, sDrop);
    chk(sDone, "R8 var 61 accepted with status", sDone, 1);
    waitDrain("R8 var 61 delivered");
    cfgVarLen = 1'b0; cfgAppend = 1'b0;
    cfgFixLen = 7'd64; mkBody(64, 16);
    sendPacket(1'b0, 1'b1, 1'b0, "R8 fix 64", sDone, sDrop);
    chk(sDone, "R8 fixed 64 accepted", sDone, 1);
    waitDrain("R8 fixed 64 delivered");
    cfgFixLen = 7'd65; mkBody(65, 17);
    sendPacket(1'b0, 1'b0, 1'b0, "R8 fix 65", sDone, sDrop);
    chk(sDrop && !sDone, "R8 fixed 65 dropped", sDrop, 1);
    cfgAppend = 1'b1;
    cfgFixLen = 7'd63; mkBody(63, 18);
    sendPacket(1'b0, 1'b0, 1'b0, "R8 fix 63 app", sDone, sDrop);
    chk(sDrop && !sDone, "R8 fixed 63 dropped with status", sDrop, 1);
    cfgFixLen = 7'd62; mkBody(62, 19);
    sendPacket(1'b0, 1'b1, 1'b0, "R8 fix 62 app", sDone, sDrop);
    chk(sDone, "R8 fixed 62 accepted with status", sDone, 1);
    waitDrain("R8 fixed 62 delivered");
    cfgAutoFlush = 1'b0;

    // R9 return to idle after a packet
    cfgVarLen = 1'b1; cfgStayRx = 1'b0;
    mkBody(3, 20);
    sendPacket(1'b0, 1'b1, 1'b0, "R9 last", sDone, sDrop);
    chk(rxActive == 1'b0, "R9 idle after packet", rxActive, 0);
    waitDrain("R9 last packet delivered");
    mkBody(3, 21);
    sendPacket(1'b0, 1'b0, 1'b0, "R9 ignored", sDone, sDrop);
    chk(!sDone && !sDrop && fifoCount == 7'd0, "R9 packet ignored while idle", sDone + sDrop, 0);
    cfgStayRx = 1'b1;
    rxStart = 1'b1;
    @(negedge clk);
    rxStart = 1'b0;
    chk(rxActive == 1'b1, "R9 relisten", rxActive, 1);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule